// File: doc/BRIEF.md
# Toggle-Acknowledge Serial Byte Link

This block carries bytes from a sending side to a receiving side over three wires: a data wire, a strobe wire driven by the sender, and a reply wire driven by the receiver. The sender puts one bit on the data wire. It then inverts the strobe wire. The receiver takes the bit when it sees the strobe level change, in either direction. It answers by inverting the reply wire. The sender holds the data and strobe wires still until that reply arrives. Because of this the link runs as fast as the receiver answers, and it loses nothing however long the receiver pauses.

Each side has a byte-wide valid/ready port. A byte accepted on the transmit port leaves most-significant bit first, as eight strobe changes. After the eighth bit the receiver presents the byte on its output port. It withholds the last reply until that byte is taken. As a result, the sender cannot finish a byte and start the next one before the receiver has room. Both incoming wire levels pass through flip-flop synchronizers. Each side detects a change by comparing the synchronized level with the last level it acted on.

The top module instantiates both ends and brings the three wires out as outputs, so that they can be observed.

Top module: `toggle_bit_link`

## Requirements
- R1: While reset is high, and in the first cycle after it, link_strobe, link_data and link_reply are 0, tx_ready is 1 and rx_valid is 0.
- R2: The bit carried by the k-th strobe change of a byte (k = 1..8) is bit 8-k of that byte, so bits go most-significant first.
- R3: link_data never changes in the same cycle as link_strobe. Each bit is set up at least one cycle before its strobe change.
- R4: Rising and falling strobe changes both carry a bit; no edge polarity is reserved.
- R5: Every strobe change is answered by exactly one reply change. The count of reply changes is always equal to the count of strobe changes, or one less.
- R6: After a strobe change, the sender changes neither link_strobe nor link_data until a reply change has been seen.
- R7: A byte uses exactly eight strobe changes and eight reply changes. tx_ready stays low from acceptance until the eighth reply.
- R8: rx_valid rises after the eighth bit with the assembled byte on rx_data. Both hold steady until rx_ready is high.
- R9: While rx_valid is high and rx_ready is low, link_reply does not change; the final reply of the byte is withheld.
- R10: Bytes leave rx_data in the order and with the values accepted on tx_data, whatever the pattern or length of rx_ready stalls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both ends |
| rst | input | 1 | Synchronous active-high reset |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Sender idle, byte will be accepted |
| tx_data | input | DATA_W | Byte to transmit |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Consumer takes the received byte |
| rx_data | output | DATA_W | Received byte |
| link_strobe | output | 1 | Strobe wire, inverted once per bit by the sender |
| link_data | output | 1 | Data wire |
| link_reply | output | 1 | Reply wire, inverted once per bit by the receiver |

## Verification
Suppose the sender's bit counter or shift register holds a wrong value. The wrong bit shows on link_data at the next strobe change, within about seven cycles, and the bench compares it against the expected byte there. Suppose the sender misreads the reply, or moves on without one. The strobe and reply change counts then diverge by more than one on the very next strobe change. Suppose the receiver releases its final reply early, or miscounts bits. Then either link_reply moves during a stall, or a wrong byte appears on rx_data within one byte time.

// File: rtl/tbl_pkg.sv
package tbl_pkg;
  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_SETUP = 2'd1,
    TX_WAIT  = 2'd2
  } tx_state_e;
endpackage

// File: rtl/tbl_sync.sv
module tbl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain_q[i] <= 1'b0;
          else     chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/tbl_tx.sv
module tbl_tx
  import tbl_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              strobe,
  output logic              data,
  input  logic              reply
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  tx_state_e         state_q;
  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              strobe_q, data_q, reply_seen_q;
  logic              reply_s;
  logic              reply_edge;

  tbl_sync #(.STAGES(SYNC_STAGES)) u_reply_sync (
    .clk(clk), .rst(rst), .d(reply), .q(reply_s)
  );

  assign reply_edge = reply_s ^ reply_seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= TX_IDLE;
      sh_q         <= '0;
      cnt_q        <= '0;
      strobe_q     <= 1'b0;
      data_q       <= 1'b0;
      reply_seen_q <= 1'b0;
    end else begin
      case (state_q)
        TX_IDLE: begin
          if (in_valid) begin
            sh_q    <= in_data;
            data_q  <= in_data[DATA_W-1];
            cnt_q   <= '0;
            state_q <= TX_SETUP;
          end
        end
        TX_SETUP: begin
          strobe_q <= ~strobe_q;
          state_q  <= TX_WAIT;
        end
        TX_WAIT: begin
          if (reply_edge) begin
            reply_seen_q <= reply_s;
            if (cnt_q == LAST_BIT) begin
              state_q <= TX_IDLE;
            end else begin
              cnt_q   <= cnt_q + 1'b1;
              sh_q    <= sh_q << 1;
              data_q  <= sh_q[DATA_W-2];
              state_q <= TX_SETUP;
            end
          end
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end

  assign in_ready = (state_q == TX_IDLE);
  assign strobe   = strobe_q;
  assign data     = data_q;

  // R6: waiting without a reply change freezes both wires
  p_hold_until_reply_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == TX_WAIT && !reply_edge) |=> ($stable(strobe_q) && $stable(data_q)));

  // R3: the strobe only moves when leaving setup, a cycle after data settled
  p_strobe_after_setup_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q != TX_SETUP) |=> $stable(strobe_q));

  // R7: no new byte accepted while a transfer is in flight
  p_busy_not_ready_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == TX_WAIT) |-> !in_ready);
endmodule

// File: rtl/tbl_rx.sv
module tbl_rx #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic              data,
  output logic              reply,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic              strobe_s, strobe_seen_q, strobe_edge;
  logic [DATA_W-2:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              reply_q, valid_q;
  logic [DATA_W-1:0] byte_q;

  tbl_sync #(.STAGES(SYNC_STAGES)) u_strobe_sync (
    .clk(clk), .rst(rst), .d(strobe), .q(strobe_s)
  );

  assign strobe_edge = strobe_s ^ strobe_seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_seen_q <= 1'b0;
      sh_q          <= '0;
      cnt_q         <= '0;
      reply_q       <= 1'b0;
      valid_q       <= 1'b0;
      byte_q        <= '0;
    end else if (valid_q) begin
      if (out_ready) begin
        valid_q <= 1'b0;
        reply_q <= ~reply_q;
      end
    end else if (strobe_edge) begin
      strobe_seen_q <= strobe_s;
      sh_q          <= {sh_q[DATA_W-3:0], data};
      if (cnt_q == LAST_BIT) begin
        cnt_q   <= '0;
        valid_q <= 1'b1;
        byte_q  <= {sh_q, data};
      end else begin
        cnt_q   <= cnt_q + 1'b1;
        reply_q <= ~reply_q;
      end
    end
  end

  assign reply     = reply_q;
  assign out_valid = valid_q;
  assign out_data  = byte_q;

  // R9: the final reply is withheld while the byte waits
  p_final_reply_held_r9: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !out_ready) |=> $stable(reply_q));

  // R8: output byte stays put until consumed
  p_byte_held_r8: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !out_ready) |=> (valid_q && $stable(byte_q)));

  // R5: reply changes only on a strobe change or a consumed byte
  p_reply_has_cause_r5: assert property (@(posedge clk) disable iff (rst)
    (!strobe_edge && !(valid_q && out_ready)) |=> $stable(reply_q));
endmodule

// File: rtl/toggle_bit_link.sv
module toggle_bit_link #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              link_strobe,
  output logic              link_data,
  output logic              link_reply
);
  logic w_strobe, w_data, w_reply;

  tbl_tx #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_tx (
    .clk(clk), .rst(rst),
    .in_valid(tx_valid), .in_ready(tx_ready), .in_data(tx_data),
    .strobe(w_strobe), .data(w_data), .reply(w_reply)
  );

  tbl_rx #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst(rst),
    .strobe(w_strobe), .data(w_data), .reply(w_reply),
    .out_valid(rx_valid), .out_ready(rx_ready), .out_data(rx_data)
  );

  assign link_strobe = w_strobe;
  assign link_data   = w_data;
  assign link_reply  = w_reply;

  // R3: data wire and strobe wire never move in the same cycle
  p_data_setup_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(w_strobe) |-> $stable(w_data));
endmodule

// File: tb/toggle_bit_link_tb.sv
module toggle_bit_link_tb_top;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_valid = 1'b0;
  logic [DW-1:0] tx_data = '0;
  logic rx_ready = 1'b0;
  logic tx_ready, rx_valid, link_strobe, link_data, link_reply;
  logic [DW-1:0] rx_data;

  int checks = 0;
  int fails  = 0;
  int rdy_mode = 0;      // 0: always ready, 1: random, 2: never
  bit finished = 0;

  logic [DW-1:0] sent[$];
  int ridx = 0;
  int strobe_cnt = 0, reply_cnt = 0, rises = 0, falls = 0;
  logic p_strobe = 0, p_data = 0, p_reply = 0, p_valid = 0, p_ready = 0;
  logic [DW-1:0] p_rxd = '0;

  always #5 clk = ~clk;

  toggle_bit_link #(.DATA_W(DW), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .link_strobe(link_strobe), .link_data(link_data), .link_reply(link_reply)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Ready driver
  always @(posedge clk) begin
    #1;
    case (rdy_mode)
      0: rx_ready = 1'b1;
      1: rx_ready = ($urandom % 4) == 0;
      default: rx_ready = 1'b0;
    endcase
  end

  // Cycle-by-cycle reference model of the wire protocol
  always @(negedge clk) begin
    if (!rst) begin
      if (tx_valid && tx_ready) sent.push_back(tx_data);
      if (link_strobe != p_strobe) begin
        check(link_data == p_data, "R3", "data moved with strobe", link_data, p_data);
        check(strobe_cnt == reply_cnt, "R6", "strobe before reply", strobe_cnt, reply_cnt);
        if (strobe_cnt / DW < sent.size()) begin
          logic exp_bit;
          exp_bit = sent[strobe_cnt / DW][DW - 1 - (strobe_cnt % DW)];
          check(link_data == exp_bit, "R2", "bit value", link_data, exp_bit);
        end else begin
          check(1'b0, "R7", "strobe with no byte", strobe_cnt, sent.size() * DW);
        end
        if (link_strobe) rises++; else falls++;
        strobe_cnt++;
      end
      if (link_reply != p_reply) begin
        reply_cnt++;
        check(reply_cnt == strobe_cnt, "R5", "reply count", reply_cnt, strobe_cnt);
      end
      if (p_valid && !p_ready) begin
        check(rx_valid == 1'b1, "R8", "valid dropped", rx_valid, 1);
        check(rx_data == p_rxd, "R8", "data moved", rx_data, p_rxd);
        check(link_reply == p_reply, "R9", "reply during stall", link_reply, p_reply);
      end
      if (rx_valid && rx_ready) begin
        if (ridx < sent.size())
          check(rx_data == sent[ridx], "R10", "received byte", rx_data, sent[ridx]);
        else
          check(1'b0, "R10", "unexpected byte", rx_data, 0);
        check(strobe_cnt == (ridx + 1) * DW, "R8", "valid before 8th bit", strobe_cnt, (ridx + 1) * DW);
        ridx++;
      end
    end
    p_strobe = link_strobe; p_data = link_data; p_reply = link_reply;
    p_valid = rx_valid; p_ready = rx_ready; p_rxd = rx_data;
  end

  task automatic send(input logic [DW-1:0] b);
    tx_valid = 1'b1;
    tx_data  = b;
    while (!tx_ready) begin @(posedge clk); #1; end
    @(posedge clk); #1;
    tx_valid = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while (ridx < sent.size() && n < 5000) begin @(posedge clk); #1; n++; end
    check(ridx == sent.size(), "R10", "drain", ridx, sent.size());
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(link_strobe == 0, "R1", "strobe at reset", link_strobe, 0);
    check(link_data == 0, "R1", "data at reset", link_data, 0);
    check(link_reply == 0, "R1", "reply at reset", link_reply, 0);
    check(tx_ready == 1, "R1", "tx_ready at reset", tx_ready, 1);
    check(rx_valid == 0, "R1", "rx_valid at reset", rx_valid, 0);
    @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    check(tx_ready == 1 && rx_valid == 0, "R1", "first cycle after reset", {tx_ready, rx_valid}, 2);
    @(posedge clk); #1;

    // Directed patterns, consumer always ready
    rdy_mode = 0;
    send(8'h56); send(8'hFF); send(8'h00); send(8'h80); send(8'h01); send(8'hA5);
    drain();

    // Random consumer stalls
    rdy_mode = 1;
    for (int i = 0; i < 20; i++) send(8'($urandom));
    drain();

    // Long stall: byte must wait, sender must stay blocked on the final reply
    rdy_mode = 2;
    send(8'h3C);
    repeat (400) @(posedge clk);
    @(negedge clk);
    check(rx_valid == 1, "R10", "byte kept during stall", rx_valid, 1);
    check(rx_data == 8'h3C, "R10", "stalled byte value", rx_data, 8'h3C);
    check(tx_ready == 0, "R7", "sender waits on final reply", tx_ready, 0);
    check(reply_cnt == strobe_cnt - 1, "R9", "final reply withheld", reply_cnt, strobe_cnt - 1);
    @(posedge clk); #1;
    rdy_mode = 0;
    send(8'hC3);
    drain();
    repeat (20) @(posedge clk);

    @(negedge clk);
    check(strobe_cnt == sent.size() * DW, "R7", "strobe changes per byte", strobe_cnt, sent.size() * DW);
    check(reply_cnt == sent.size() * DW, "R7", "reply changes per byte", reply_cnt, sent.size() * DW);
    check(tx_ready == 1, "R7", "ready after last reply", tx_ready, 1);
    check(rises > 0, "R4", "rising edges carried bits", rises, 1);
    check(falls > 0, "R4", "falling edges carried bits", falls, 1);
    finish_run();
  end
endmodule